// File: doc/BRIEF.md
# Bidirectional Serial-to-Parallel Output Driver

This block turns a serial bit stream into a twelve-wide parallel word for an output stage. Bits enter a shift register one per rising clock edge. A direction input sets which way they move through the register. The same input decides which of two shared data pins takes the serial stream in and which one carries the far-end bit out to the next device in a chain. Each shared pin appears as a separate input, output and output-enable, so the tristate buffer stays outside the block.

A bank of level-sensitive latches sits between the register and the outputs. While the latch enable is high the latches pass the register through. When the enable drops they freeze their contents, and the register keeps shifting behind them. A polarity input can invert the frozen word, and a blanking input can force every output low.

Top module: `sipo_drv`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the shift register and the latches to 0. With `pol` and `blank` low, `pout` is then 0 and both serial outputs are 0.
- R2: With `dir` = 0, each rising edge loads `pa_i` into `pout[11]` (output 12) and moves every bit one place toward `pout[0]` (output 1). `pb_i` is ignored.
- R3: With `dir` = 1, each rising edge loads `pb_i` into `pout[0]` and moves every bit one place toward `pout[11]`. `pa_i` is ignored.
- R4: `pb_o` carries register bit 0 and `pa_o` carries register bit 11. Both are register outputs, so they change only at a rising edge.
- R5: `pa_oe` equals `dir` and `pb_oe` equals the inverse of `dir`. Both follow a change of `dir` in the same cycle, with no clock edge needed.
- R6: While `le` is high, `pout` follows the shift register contents after every edge.
- R7: While `le` is low, `pout` holds the register value that was present when `le` fell, even as the register keeps shifting.
- R8: With `blank` low and `pol` high, every `pout` bit is the inverse of its latched bit.
- R9: With `blank` high, `pout` is all zeros, whatever the latch contents and `pol`.
- R10: `le`, `blank` and `pol` have no effect on the shift register. Bits shifted while the latches are closed, blanked or inverted show up unchanged once `le` rises with `pol` and `blank` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; shifting on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 1 | Shift direction and pin-role select |
| le | input | 1 | Latch enable; high = transparent |
| blank | input | 1 | High forces all parallel outputs to 0 |
| pol | input | 1 | High inverts the parallel outputs |
| pa_i | input | 1 | Pin A input side (serial in when dir = 0) |
| pa_o | output | 1 | Pin A output side (register bit 11) |
| pa_oe | output | 1 | Pin A output enable |
| pb_i | input | 1 | Pin B input side (serial in when dir = 1) |
| pb_o | output | 1 | Pin B output side (register bit 0) |
| pb_oe | output | 1 | Pin B output enable |
| pout | output | 12 | Conditioned parallel outputs; bit k is output k+1 |

## Verification
The register, the latch snapshot and the serial outputs change at the first rising edge after the bench drives a stimulus on the falling edge. The pin enables, blanking and polarity act combinationally and are already settled by that same edge. For each falling-edge stimulus the driver computes the expected port values after the next rising edge and queues them. The monitor pops one entry per rising edge and compares it 1 ns after the edge, so every result is checked in the cycle it first becomes due.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    typedef enum logic {
        SHIFT_TO_LOW  = 1'b0,
        SHIFT_TO_HIGH = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/sipo_shift.sv
module sipo_shift #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir,
    input  logic         a_in,
    input  logic         b_in,
    output logic [W-1:0] sr,
    output logic [W-1:0] sr_next,
    output logic         low_end,
    output logic         high_end
);
    import sipo_pkg::*;

    typedef struct packed {
        logic [W-1:0] bits;
    } shift_st_t;

    shift_st_t st_d, st_q;
    shift_dir_e mode;

    always_comb begin
        mode = shift_dir_e'(dir);
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (mode == SHIFT_TO_LOW) begin
            st_d.bits = {a_in, st_q.bits[W-1:1]};
        end else begin
            st_d.bits = {st_q.bits[W-2:0], b_in};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sr       = st_q.bits;
    assign sr_next  = st_d.bits;
    assign low_end  = st_q.bits[0];
    assign high_end = st_q.bits[W-1];
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [W-1:0] sr,
    input  logic [W-1:0] sr_next,
    output logic [W-1:0] view
);
    typedef struct packed {
        logic [W-1:0] held;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.held = '0;
        end else if (le) begin
            st_d.held = sr_next;
        end
        view = le ? sr : st_q.held;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/sipo_cond.sv
module sipo_cond #(
    parameter int W = 12
) (
    input  logic [W-1:0] view,
    input  logic         pol,
    input  logic         blank,
    output logic [W-1:0] drive
);
    always_comb begin
        if (blank) begin
            drive = '0;
        end else begin
            drive = view ^ {W{pol}};
        end
    end
endmodule

// File: rtl/sipo_drv.sv
module sipo_drv #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir,
    input  logic         le,
    input  logic         blank,
    input  logic         pol,
    input  logic         pa_i,
    output logic         pa_o,
    output logic         pa_oe,
    input  logic         pb_i,
    output logic         pb_o,
    output logic         pb_oe,
    output logic [W-1:0] pout
);
    logic [W-1:0] sr_w;
    logic [W-1:0] sr_nx;
    logic [W-1:0] view_w;

    sipo_shift #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .dir      (dir),
        .a_in     (pa_i),
        .b_in     (pb_i),
        .sr       (sr_w),
        .sr_next  (sr_nx),
        .low_end  (pb_o),
        .high_end (pa_o)
    );

    sipo_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .le      (le),
        .sr      (sr_w),
        .sr_next (sr_nx),
        .view    (view_w)
    );

    sipo_cond #(.W(W)) u_cond (
        .view  (view_w),
        .pol   (pol),
        .blank (blank),
        .drive (pout)
    );

    assign pa_oe = dir;
    assign pb_oe = ~dir;
endmodule

// File: rtl/sipo_drv_chk.sv
module sipo_drv_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         dir,
    input logic         le,
    input logic         blank,
    input logic         pol,
    input logic         pa_i,
    input logic         pb_i,
    input logic         pa_oe,
    input logic         pb_oe,
    input logic [W-1:0] pout,
    input logic [W-1:0] sr
);
    assert_shift_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!dir) |=> (rst || sr == {$past(pa_i), $past(sr[W-1:1])}));

    assert_shift_high_R3: assert property (@(posedge clk) disable iff (rst)
        (dir) |=> (rst || sr == {$past(sr[W-2:0]), $past(pb_i)}));

    assert_oe_swap_R5: assert property (@(posedge clk) disable iff (rst)
        (pa_oe != pb_oe) && (pa_oe == dir));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!le) |=> (rst || le || !$stable(blank) || !$stable(pol) || $stable(pout)));

    assert_blank_R9: assert property (@(posedge clk) disable iff (rst)
        blank |-> (pout == '0));
endmodule

bind sipo_drv sipo_drv_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .dir   (dir),
    .le    (le),
    .blank (blank),
    .pol   (pol),
    .pa_i  (pa_i),
    .pb_i  (pb_i),
    .pa_oe (pa_oe),
    .pb_oe (pb_oe),
    .pout  (pout),
    .sr    (sr_w)
);

// File: tb/sipo_drv_test.sv
module sipo_drv_test;
    localparam int W = 12;

    typedef struct {
        logic [W+3:0] v;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dir = 1'b0;
    logic         le = 1'b0;
    logic         blank = 1'b0;
    logic         pol = 1'b0;
    logic         pa_i = 1'b0;
    logic         pb_i = 1'b0;
    logic         pa_o, pa_oe, pb_o, pb_oe;
    logic [W-1:0] pout;

    item_t        exp_q[$];
    int           total = 0;
    int           bad = 0;
    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_hold = '0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    sipo_drv #(.W(W)) uut (
        .clk(clk), .rst(rst), .dir(dir), .le(le), .blank(blank), .pol(pol),
        .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe), .pout(pout)
    );

    // driver: apply on falling edge, queue the values due after the next rising edge
    task automatic step(input logic r, input logic d, input logic l, input logic b,
                        input logic p, input logic ai, input logic bi, input string tag);
        item_t        it;
        logic [W-1:0] vw;
        logic [W-1:0] po;
        @(negedge clk);
        rst = r; dir = d; le = l; blank = b; pol = p; pa_i = ai; pb_i = bi;
        if (r) begin
            m_sr = '0;
            m_hold = '0;
        end else begin
            if (!d) m_sr = {ai, m_sr[W-1:1]};
            else    m_sr = {m_sr[W-2:0], bi};
            if (l) m_hold = m_sr;
        end
        vw = l ? m_sr : m_hold;
        po = b ? '0 : (vw ^ {W{p}});
        it.v = {po, m_sr[W-1], m_sr[0], d, ~d};
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: one comparison per rising edge, sampled 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t        it;
                logic [W+3:0] act;
                it = exp_q.pop_front();
                act = {pout, pa_o, pb_o, pa_oe, pb_oe};
                total++;
                if (act !== it.v) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", it.tag, act, it.v);
                end
            end
        end
    end

    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pat;
        // R1: reset state
        step(1, 0, 1, 0, 0, 1, 1, "R1");
        step(1, 0, 1, 0, 0, 1, 1, "R1");
        // R2 / R6: shift a pattern in through pin A, latches transparent
        pat = 12'hA5C;
        for (int i = 0; i < W; i++) step(0, 0, 1, 0, 0, pat[i], ~pat[i], "R2_R6");
        // R4: shift it out through pin B
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, 1, "R4");
        // R5 / R3: swap direction, shift a pattern in through pin B
        pat = 12'h3C9;
        for (int i = 0; i < W; i++) step(0, 1, 1, 0, 0, ~pat[i], pat[i], "R3_R5");
        step(0, 1, 1, 0, 0, 0, 0, "R4");
        // R7: close latches and keep shifting
        for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, 1, i[0], "R7");
        // R8: polarity inverts the held word
        step(0, 1, 0, 0, 1, 0, 1, "R8");
        step(0, 0, 0, 0, 1, 1, 0, "R8");
        // R9: blanking forces zeros under both polarities
        step(0, 0, 0, 1, 0, 1, 1, "R9");
        step(0, 0, 0, 1, 1, 0, 0, "R9");
        step(0, 0, 1, 1, 1, 1, 0, "R9");
        // R10: shift while closed, blanked and inverted, then open latches
        for (int i = 0; i < W; i++)
            step(0, 0, 0, i[1], i[0], i[0] ^ i[2], 1, "R10");
        step(0, 0, 1, 0, 0, 0, 0, "R10");
        step(0, 0, 1, 0, 0, 1, 0, "R10");
        // R5: direction flip back, with latches transparent
        step(0, 1, 1, 0, 0, 0, 1, "R5");
        // R1: reset again, mid-stream
        step(1, 1, 1, 0, 0, 1, 1, "R1");
        step(0, 0, 1, 0, 0, 0, 0, "R1");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule